// File: doc/BRIEF.md
# Dual-Priority Cell Queue Scheduler

This block manages one output queue of fixed-size cells. Each cell carries a tag and two independent class bits. The urgency bit marks a cell that should leave sooner. The keep bit marks a cell that should be lost less often. The queue is a small register array. Every arrival is placed by a combinational scan, and the whole array shifts in a single clock cycle.

Two run-time thresholds shape the queue:

- The overtake limit sets how many non-urgent cells, counted back from the tail, an arriving urgent cell may pass. An urgent cell never passes another urgent cell.
- The guard position sets which stored low-loss-priority cells may be evicted. When the queue is full and a keep cell arrives, the low-loss cell nearest the tail whose position lies beyond the guard is evicted to make room.

With these two values the same hardware behaves as first-come-first-served, strict head-of-line priority, unrestricted push-out, or head-of-line priority with push-out.

A downstream port reads the head cell when it is ready. A departure is applied before an arrival in the same cycle. The block reports drops, evictions (with the evicted tag) and its current occupancy.

Top module: `cellq_sched`

## Requirements
- R1: A synchronous active-high reset empties the queue, clears the drop and push-out flags, and sets the overtake limit to 0 and the guard position to DEPTH, which gives first-come-first-served order regardless of class bits.
- R2: A non-urgent arrival (urgent bit 0) is appended at the tail whenever the queue has room.
- R3: An urgent arrival is placed ahead of the trailing run of non-urgent cells, passing min(limit, run length) of them, and never ahead of a stored urgent cell.
- R4: The head cell is shown on the departure port while the queue is non-empty and is removed on a cycle with departure ready. A departure and an arrival in the same cycle apply the departure first, so a full queue then admits the arrival with no drop and no eviction.
- R5: When the queue is full and an arrival has keep bit 1, the cell with keep bit 0 that is nearest the tail and at a position (1 = head) greater than the guard is removed. The arrival is then inserted by the rules of R2 and R3. On the next cycle, push_o pulses for one cycle and push_tag_o shows the evicted tag.
- R6: A full-queue arrival with keep bit 0, or with no eligible victim, is discarded and the stored cells are unchanged; drop_o pulses for one cycle. drop_o and push_o are never high together.
- R7: A cycle with cfg_we_i high loads both thresholds, which govern arrivals from the next cycle on. A value above DEPTH is stored as DEPTH.
- R8: occ_o equals the number of stored cells and never exceeds DEPTH.
- R9: With an overtake limit of at least DEPTH, urgent cells leave before all non-urgent cells (strict head-of-line). With a guard of 0, any low-loss cell may be evicted, including the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid_i | input | 1 | Arrival present this cycle |
| arr_tag_i | input | TAG_W | Arriving cell tag |
| arr_urgent_i | input | 1 | Arriving cell urgency (1 = high delay priority) |
| arr_keep_i | input | 1 | Arriving cell keep bit (1 = high loss priority) |
| dep_ready_i | input | 1 | Downstream takes the head cell this cycle |
| dep_valid_o | output | 1 | Queue non-empty, head cell shown |
| dep_tag_o | output | TAG_W | Head cell tag |
| dep_urgent_o | output | 1 | Head cell urgency bit |
| dep_keep_o | output | 1 | Head cell keep bit |
| cfg_we_i | input | 1 | Load both thresholds |
| cfg_lim_i | input | CW | New overtake limit |
| cfg_guard_i | input | CW | New guard position |
| lim_o | output | CW | Current overtake limit |
| guard_o | output | CW | Current guard position |
| drop_o | output | 1 | One-cycle pulse: last arrival discarded |
| push_o | output | 1 | One-cycle pulse: a stored cell was evicted |
| push_tag_o | output | TAG_W | Tag of the most recently evicted cell |
| occ_o | output | CW | Number of stored cells |

## Verification
The bench builds the block with DEPTH = 8 and TAG_W = 8, so the queue fills within eight arrivals. At that depth every full-queue path can be reached in a few cycles: eviction, drop, and the combined departure-plus-arrival case. With a 4-bit threshold field, values 9 to 15 exercise the clamp. Limit and guard values from 0 to DEPTH are all reached, which covers the first-come-first-served, strict head-of-line and unrestricted push-out settings.

// File: rtl/cellq_pkg.sv
package cellq_pkg;

   // Class bits carried by every stored cell.
   typedef struct packed {
      logic urgent;   // high delay priority
      logic keep;     // high loss priority
   } cell_cls_t;

   // Outcome of one arrival slot.
   typedef enum logic [1:0] {
      ARR_IDLE  = 2'd0,
      ARR_ADMIT = 2'd1,
      ARR_EVICT = 2'd2,
      ARR_DROP  = 2'd3
   } arr_outcome_e;

endpackage

// File: rtl/cellq_cfg.sv
module cellq_cfg
   import cellq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter bit CLAMP = 1'b1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_i,
   input  logic [CW-1:0] lim_i,
   input  logic [CW-1:0] guard_i,
   output logic [CW-1:0] lim_o,
   output logic [CW-1:0] guard_o
);

   logic [CW-1:0] lim_n, guard_n;
   logic [CW-1:0] lim_q, guard_q;

   generate
      if (CLAMP) begin : g_clamp
         assign lim_n   = (lim_i   > CW'(DEPTH)) ? CW'(DEPTH) : lim_i;
         assign guard_n = (guard_i > CW'(DEPTH)) ? CW'(DEPTH) : guard_i;
      end else begin : g_raw
         assign lim_n   = lim_i;
         assign guard_n = guard_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         lim_q   <= '0;
         guard_q <= CW'(DEPTH);
      end else if (we_i) begin
         lim_q   <= lim_n;
         guard_q <= guard_n;
      end
   end

   assign lim_o   = lim_q;
   assign guard_o = guard_q;

endmodule

// File: rtl/cellq_victim.sv
module cellq_victim
   import cellq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  cell_cls_t     cls_i [DEPTH],
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] guard_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   // Eligible entries: stored, low loss priority, position (1-based) beyond guard.
   logic [DEPTH-1:0] elig;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_elig
         assign elig[i] = (CW'(i) < cnt_i) && !cls_i[i].keep && (CW'(i + 1) > guard_i);
      end
   endgenerate

   // Highest eligible index (nearest the tail) wins.
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (elig[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/cellq_slot.sv
module cellq_slot
   import cellq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  cell_cls_t     cls_i [DEPTH],
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] lim_i,
   input  logic          urgent_i,
   output logic [CW-1:0] pos_o
);

   logic [DEPTH-1:0] urg_vec;
   logic [CW-1:0]    floor_pos;   // one past the last stored urgent cell
   logic [CW-1:0]    run_len;     // trailing non-urgent cells
   logic [CW-1:0]    pass_cnt;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_urg
         assign urg_vec[i] = (CW'(i) < cnt_i) && cls_i[i].urgent;
      end
   endgenerate

   always_comb begin
      floor_pos = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (urg_vec[i]) floor_pos = CW'(i + 1);
      end
   end

   assign run_len  = cnt_i - floor_pos;
   assign pass_cnt = (lim_i < run_len) ? lim_i : run_len;
   assign pos_o    = urgent_i ? (cnt_i - pass_cnt) : cnt_i;

endmodule

// File: rtl/cellq_sched.sv
module cellq_sched
   import cellq_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int TAG_W        = 8,
   parameter bit CLAMP_THRESH = 1'b1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int IW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             arr_valid_i,
   input  logic [TAG_W-1:0] arr_tag_i,
   input  logic             arr_urgent_i,
   input  logic             arr_keep_i,
   input  logic             dep_ready_i,
   output logic             dep_valid_o,
   output logic [TAG_W-1:0] dep_tag_o,
   output logic             dep_urgent_o,
   output logic             dep_keep_o,
   input  logic             cfg_we_i,
   input  logic [CW-1:0]    cfg_lim_i,
   input  logic [CW-1:0]    cfg_guard_i,
   output logic [CW-1:0]    lim_o,
   output logic [CW-1:0]    guard_o,
   output logic             drop_o,
   output logic             push_o,
   output logic [TAG_W-1:0] push_tag_o,
   output logic [CW-1:0]    occ_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cellq_sched: DEPTH must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("cellq_sched: TAG_W must be at least 1");
      end
   endgenerate

   // ---------------------------------------------------------------
   // Storage
   // ---------------------------------------------------------------
   logic [TAG_W-1:0] tag_q [DEPTH];
   cell_cls_t        cls_q [DEPTH];
   logic [CW-1:0]    cnt_q;
   logic             drop_q, push_q;
   logic [TAG_W-1:0] push_tag_q;

   // ---------------------------------------------------------------
   // Thresholds
   // ---------------------------------------------------------------
   logic [CW-1:0] lim, guard;

   cellq_cfg #(
      .DEPTH (DEPTH),
      .CLAMP (CLAMP_THRESH)
   ) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .we_i    (cfg_we_i),
      .lim_i   (cfg_lim_i),
      .guard_i (cfg_guard_i),
      .lim_o   (lim),
      .guard_o (guard)
   );

   // ---------------------------------------------------------------
   // Stage A: departure removes the head
   // ---------------------------------------------------------------
   logic             deq;
   logic [TAG_W-1:0] tag_a [DEPTH];
   cell_cls_t        cls_a [DEPTH];
   logic [CW-1:0]    cnt_a;

   assign deq   = dep_ready_i && (cnt_q != '0);
   assign cnt_a = cnt_q - CW'(deq);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage_a
         if (i == DEPTH - 1) begin : g_last
            assign tag_a[i] = deq ? '0 : tag_q[i];
            assign cls_a[i] = deq ? '0 : cls_q[i];
         end else begin : g_mid
            assign tag_a[i] = deq ? tag_q[i+1] : tag_q[i];
            assign cls_a[i] = deq ? cls_q[i+1] : cls_q[i];
         end
      end
   endgenerate

   // ---------------------------------------------------------------
   // Stage B: eviction on a full queue
   // ---------------------------------------------------------------
   logic             full_a;
   logic             v_found;
   logic [IW-1:0]    v_idx;
   arr_outcome_e     outcome;
   logic             evict, drop, admit;
   logic [TAG_W-1:0] tag_b [DEPTH];
   cell_cls_t        cls_b [DEPTH];
   logic [CW-1:0]    cnt_b;

   assign full_a = (cnt_a == CW'(DEPTH));

   cellq_victim #(
      .DEPTH (DEPTH)
   ) u_victim (
      .cls_i   (cls_a),
      .cnt_i   (cnt_a),
      .guard_i (guard),
      .found_o (v_found),
      .idx_o   (v_idx)
   );

   always_comb begin
      if (!arr_valid_i)                   outcome = ARR_IDLE;
      else if (!full_a)                   outcome = ARR_ADMIT;
      else if (arr_keep_i && v_found)     outcome = ARR_EVICT;
      else                                outcome = ARR_DROP;
   end

   assign evict = (outcome == ARR_EVICT);
   assign drop  = (outcome == ARR_DROP);
   assign admit = (outcome == ARR_ADMIT) || evict;
   assign cnt_b = cnt_a - CW'(evict);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage_b
         if (i == DEPTH - 1) begin : g_last
            assign tag_b[i] = tag_a[i];
            assign cls_b[i] = cls_a[i];
         end else begin : g_mid
            logic close_gap;
            assign close_gap = evict && (IW'(i) >= v_idx);
            assign tag_b[i]  = close_gap ? tag_a[i+1] : tag_a[i];
            assign cls_b[i]  = close_gap ? cls_a[i+1] : cls_a[i];
         end
      end
   endgenerate

   // ---------------------------------------------------------------
   // Stage C: insertion at the computed slot
   // ---------------------------------------------------------------
   logic [CW-1:0]    ins_pos;
   cell_cls_t        new_cls;
   logic [TAG_W-1:0] tag_c [DEPTH];
   cell_cls_t        cls_c [DEPTH];
   logic [CW-1:0]    cnt_c;

   assign new_cls.urgent = arr_urgent_i;
   assign new_cls.keep   = arr_keep_i;

   cellq_slot #(
      .DEPTH (DEPTH)
   ) u_slot (
      .cls_i    (cls_b),
      .cnt_i    (cnt_b),
      .lim_i    (lim),
      .urgent_i (arr_urgent_i),
      .pos_o    (ins_pos)
   );

   assign cnt_c = cnt_b + CW'(admit);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage_c
         logic at_slot, after_slot;
         assign at_slot    = admit && (CW'(i) == ins_pos);
         assign after_slot = admit && (CW'(i) >  ins_pos);
         if (i == 0) begin : g_head
            assign tag_c[i] = at_slot ? arr_tag_i : tag_b[i];
            assign cls_c[i] = at_slot ? new_cls   : cls_b[i];
         end else begin : g_rest
            assign tag_c[i] = at_slot ? arr_tag_i : (after_slot ? tag_b[i-1] : tag_b[i]);
            assign cls_c[i] = at_slot ? new_cls   : (after_slot ? cls_b[i-1] : cls_b[i]);
         end
      end
   endgenerate

   // ---------------------------------------------------------------
   // State update
   // ---------------------------------------------------------------
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i] <= '0;
            cls_q[i] <= '0;
         end
         cnt_q      <= '0;
         drop_q     <= 1'b0;
         push_q     <= 1'b0;
         push_tag_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i] <= tag_c[i];
            cls_q[i] <= cls_c[i];
         end
         cnt_q  <= cnt_c;
         drop_q <= drop;
         push_q <= evict;
         if (evict) push_tag_q <= tag_a[v_idx];
      end
   end

   // ---------------------------------------------------------------
   // Outputs
   // ---------------------------------------------------------------
   assign dep_valid_o  = (cnt_q != '0);
   assign dep_tag_o    = tag_q[0];
   assign dep_urgent_o = cls_q[0].urgent;
   assign dep_keep_o   = cls_q[0].keep;
   assign lim_o        = lim;
   assign guard_o      = guard;
   assign drop_o       = drop_q;
   assign push_o       = push_q;
   assign push_tag_o   = push_tag_q;
   assign occ_o        = cnt_q;

endmodule

// File: rtl/cellq_sched_chk.sv
module cellq_sched_chk #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          arr_valid_i,
   input logic          arr_keep_i,
   input logic          dep_ready_i,
   input logic          dep_valid_o,
   input logic          cfg_we_i,
   input logic [CW-1:0] cfg_lim_i,
   input logic [CW-1:0] cfg_guard_i,
   input logic [CW-1:0] lim_o,
   input logic [CW-1:0] guard_o,
   input logic          drop_o,
   input logic          push_o,
   input logic [CW-1:0] occ_o
);

   // R1: leaving reset gives an empty queue in first-come-first-served setting
   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (occ_o == '0) && (lim_o == '0) && (guard_o == CW'(DEPTH)) && !drop_o && !push_o);

   // R8: occupancy bounded
   p_occ_bound_r8: assert property (@(posedge clk) disable iff (rst)
      occ_o <= CW'(DEPTH));

   // R8: occupancy follows departures and admitted arrivals
   p_occ_step_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |->
         int'(occ_o) == int'($past(occ_o)) - int'($past(dep_ready_i && dep_valid_o))
                        + int'($past(arr_valid_i) && !drop_o && !push_o));

   // R6: drop and eviction pulses are exclusive
   p_drop_push_excl_r6: assert property (@(posedge clk) disable iff (rst)
      !(drop_o && push_o));

   // R6: low-loss arrival into a full queue without departure is dropped
   p_drop_full_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(arr_valid_i && !arr_keep_i && !dep_ready_i && (occ_o == CW'(DEPTH)))
      |-> drop_o);

   // R5 / R4: eviction only for a keep arrival into a full queue with no departure
   p_push_cause_r5: assert property (@(posedge clk) disable iff (rst)
      push_o |-> $past(arr_valid_i && arr_keep_i && !dep_ready_i) && ($past(occ_o) == CW'(DEPTH)));

   // R7: written thresholds in range appear on the next cycle
   p_cfg_lim_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(cfg_we_i) && ($past(cfg_lim_i) <= CW'(DEPTH)) |-> lim_o == $past(cfg_lim_i));

   p_cfg_guard_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(cfg_we_i) && ($past(cfg_guard_i) <= CW'(DEPTH)) |-> guard_o == $past(cfg_guard_i));

endmodule

bind cellq_sched cellq_sched_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .arr_valid_i (arr_valid_i),
   .arr_keep_i  (arr_keep_i),
   .dep_ready_i (dep_ready_i),
   .dep_valid_o (dep_valid_o),
   .cfg_we_i    (cfg_we_i),
   .cfg_lim_i   (cfg_lim_i),
   .cfg_guard_i (cfg_guard_i),
   .lim_o       (lim_o),
   .guard_o     (guard_o),
   .drop_o      (drop_o),
   .push_o      (push_o),
   .occ_o       (occ_o)
);

// File: tb/cellq_sched_bench.sv
module cellq_sched_bench;

   localparam int DEPTH = 8;
   localparam int TAG_W = 8;
   localparam int CW    = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst;
   logic             arr_valid, arr_urgent, arr_keep, dep_ready, cfg_we;
   logic [TAG_W-1:0] arr_tag;
   logic             dep_valid, dep_urgent, dep_keep;
   logic [TAG_W-1:0] dep_tag, push_tag;
   logic [CW-1:0]    cfg_lim, cfg_guard, lim, guard, occ;
   logic             drop, push;

   always #4 clk = ~clk;   // 125 MHz

   cellq_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cellq_sched (
      .clk (clk), .rst (rst),
      .arr_valid_i (arr_valid), .arr_tag_i (arr_tag),
      .arr_urgent_i (arr_urgent), .arr_keep_i (arr_keep),
      .dep_ready_i (dep_ready), .dep_valid_o (dep_valid), .dep_tag_o (dep_tag),
      .dep_urgent_o (dep_urgent), .dep_keep_o (dep_keep),
      .cfg_we_i (cfg_we), .cfg_lim_i (cfg_lim), .cfg_guard_i (cfg_guard),
      .lim_o (lim), .guard_o (guard),
      .drop_o (drop), .push_o (push), .push_tag_o (push_tag), .occ_o (occ)
   );

   typedef struct {
      logic [TAG_W-1:0] tag;
      bit               urg;
      bit               keep;
   } mcell_t;

   mcell_t mq[$];
   int     lim_m, guard_m;
   int     n_chk = 0, n_err = 0;
   string  cur_req = "R1";
   bit     done = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Scoreboard update following the requirements.
   function automatic void model_arrive(input mcell_t c, input bit deq,
                                        output bit edrop, output bit epush, output int etag);
      mcell_t f;
      int n, v, base, run, take, pos;
      edrop = 0; epush = 0; etag = 0;
      if (deq) f = mq.pop_front();
      n = mq.size();
      if (n == DEPTH) begin
         v = -1;
         if (c.keep)
            for (int i = 0; i < n; i++)
               if (!mq[i].keep && (i + 1) > guard_m) v = i;
         if (v < 0) edrop = 1;
         else begin
            epush = 1;
            etag  = int'(mq[v].tag);
            mq.delete(v);
         end
      end
      if (!edrop) begin
         n = mq.size();
         base = 0;
         for (int i = 0; i < n; i++) if (mq[i].urg) base = i + 1;
         run  = n - base;
         take = (lim_m < run) ? lim_m : run;
         pos  = c.urg ? n - take : n;
         mq.insert(pos, c);
      end
      if (deq) mq.push_front(f);
   endfunction

   // Monitor: compare each departing head with the scoreboard front.
   always @(negedge clk) begin
      #2;
      if (!rst && dep_ready && dep_valid) begin
         if (mq.size() == 0) chk(1'b0, "R4", "departure from empty model", int'(dep_tag), -1);
         else begin
            chk(dep_tag == mq[0].tag, cur_req, "departing tag", int'(dep_tag), int'(mq[0].tag));
            void'(mq.pop_front());
         end
      end
   end

   // One cycle of stimulus; caller is at a falling edge.
   task automatic cycle(input bit av, input int tg, input bit u, input bit k, input bit dr);
      bit ed, ep;
      int et;
      mcell_t c;
      arr_valid  = av;
      arr_tag    = TAG_W'(tg);
      arr_urgent = u;
      arr_keep   = k;
      dep_ready  = dr;
      ed = 0; ep = 0; et = 0;
      if (av) begin
         c.tag = TAG_W'(tg); c.urg = u; c.keep = k;
         model_arrive(c, dr && (mq.size() > 0), ed, ep, et);
      end
      @(negedge clk);
      arr_valid = 0;
      dep_ready = 0;
      chk(drop == ed, (ed ? "R6" : cur_req), "drop pulse", int'(drop), int'(ed));
      chk(push == ep, (ep ? "R5" : cur_req), "push-out pulse", int'(push), int'(ep));
      if (ep) chk(int'(push_tag) == et, "R5", "evicted tag", int'(push_tag), et);
      chk(int'(occ) == mq.size(), "R8", "occupancy", int'(occ), mq.size());
   endtask

   task automatic set_cfg(input int l, input int r);
      int el, er;
      cfg_we    = 1;
      cfg_lim   = CW'(l);
      cfg_guard = CW'(r);
      @(negedge clk);
      cfg_we  = 0;
      lim_m   = l;
      guard_m = r;
      el = (l > DEPTH) ? DEPTH : l;
      er = (r > DEPTH) ? DEPTH : r;
      chk(int'(lim) == el, "R7", "overtake limit", int'(lim), el);
      chk(int'(guard) == er, "R7", "guard position", int'(guard), er);
   endtask

   task automatic drain();
      int guard_cnt = 0;
      while (mq.size() > 0 && guard_cnt < 4 * DEPTH) begin
         cycle(0, 0, 0, 0, 1);
         guard_cnt++;
      end
      chk(dep_valid == 1'b0, cur_req, "queue empty after drain", int'(dep_valid), 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst = 1; arr_valid = 0; arr_tag = 0; arr_urgent = 0; arr_keep = 0;
      dep_ready = 0; cfg_we = 0; cfg_lim = 0; cfg_guard = 0;
      lim_m = 0; guard_m = DEPTH;
      repeat (3) @(negedge clk);
      rst = 0;

      // R1: reset state
      chk(occ == 0, "R1", "occupancy after reset", int'(occ), 0);
      chk(dep_valid == 0, "R1", "dep_valid after reset", int'(dep_valid), 0);
      chk(!drop && !push, "R1", "flags after reset", int'(drop) + int'(push), 0);
      chk(int'(lim) == 0, "R1", "limit after reset", int'(lim), 0);
      chk(int'(guard) == DEPTH, "R1", "guard after reset", int'(guard), DEPTH);

      // R1 / R2: first-come-first-served with class bits mixed
      cur_req = "R1";
      cycle(1, 8'h01, 0, 0, 0);
      cycle(1, 8'h02, 1, 1, 0);
      cycle(1, 8'h03, 0, 1, 0);
      cycle(1, 8'h04, 1, 0, 0);
      drain();

      // R3: bounded overtake, never past a stored urgent cell
      cur_req = "R3";
      set_cfg(2, DEPTH);
      cycle(1, 8'h11, 0, 0, 0);
      cycle(1, 8'h12, 0, 0, 0);
      cycle(1, 8'h13, 0, 0, 0);
      cycle(1, 8'h21, 1, 0, 0);   // passes 0x12, 0x13
      cycle(1, 8'h22, 1, 0, 0);   // stops behind 0x21
      cycle(1, 8'h14, 0, 0, 0);   // R2: tail
      chk(dep_tag == 8'h11, "R3", "head before drain", int'(dep_tag), 'h11);
      drain();

      // R9: strict head-of-line
      cur_req = "R9";
      set_cfg(DEPTH, DEPTH);
      cycle(1, 8'h31, 0, 0, 0);
      cycle(1, 8'h32, 0, 0, 0);
      cycle(1, 8'h41, 1, 0, 0);
      chk(dep_tag == 8'h41, "R9", "urgent at head", int'(dep_tag), 'h41);
      drain();

      // R5 / R6: fill, then evict beyond guard 4, then drop
      cur_req = "R5";
      set_cfg(0, 4);
      for (int i = 0; i < DEPTH; i++)
         cycle(1, 8'h50 + i, 0, !(i == 1 || i == 4 || i == 6), 0);
      cycle(1, 8'h60, 1, 1, 0);      // evicts 0x56 (position 7)
      chk(push_tag == 8'h56, "R5", "nearest-tail victim", int'(push_tag), 'h56);
      cycle(1, 8'h61, 0, 1, 0);      // evicts 0x54 (position 5)
      cur_req = "R6";
      cycle(1, 8'h62, 0, 1, 0);      // only position 2 left, drop
      cycle(1, 8'h63, 0, 0, 0);      // low-loss arrival, drop
      cur_req = "R9";
      set_cfg(0, 0);
      cycle(1, 8'h64, 0, 1, 0);      // evicts 0x51 (position 2)
      chk(push_tag == 8'h51, "R9", "guard 0 victim", int'(push_tag), 'h51);

      // R4: full queue, departure and arrival together
      cur_req = "R4";
      cycle(1, 8'h65, 0, 0, 1);
      chk(int'(occ) == DEPTH, "R4", "still full after swap", int'(occ), DEPTH);
      drain();

      // R7: clamp of out-of-range values
      cur_req = "R7";
      set_cfg(DEPTH + 3, DEPTH + 5);

      // Mixed traffic against the scoreboard
      cur_req = "R3";
      for (int t = 0; t < 600; t++) begin
         if (t % 60 == 59) set_cfg($urandom_range(0, DEPTH + 1), $urandom_range(0, DEPTH + 1));
         else cycle($urandom_range(0, 9) < 7, $urandom_range(0, 255),
                    $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 9) < 4);
      end
      drain();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule